// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the pad synchronisers of an I2C slave port. It runs on a fast system clock and watches already-synchronised samples of the clock and data lines. It finds a START condition and shifts in the address byte or bytes that follow. It then decides whether the device's own address was called. A mode input picks how a 10-bit own-address value is read: either its low seven bits form a 7-bit address, or all ten bits form a 10-bit address. A 10-bit address is sent as a header byte followed by a low byte.

When the address matches, the block pulls the data line low during the ninth clock to acknowledge. It also gives a one-cycle match strobe, the direction bit, and a one-cycle interrupt pulse on the falling clock edge that ends the acknowledge. In 10-bit mode it keeps a status flag. The flag is clear while only the header has matched and is set once all ten bits have matched. With that flag set, a repeated START and the header sent with the read bit put the slave straight into the transmit direction. Data bytes, buffering, pad drivers and master functions belong to neighbouring blocks.

Top module: `i2c_addr_match`

## Requirements
- R1: With `ten_bit_en` = 0, `own_addr[6:0]` is compared with received bits 7..1 of the first byte after START (bit 7 is sent first). `own_addr[9:7]` plays no part. Received bit 0 is the direction bit (1 = read) and is reported on `dir_read` after a match.
- R2: A START is SDA falling while SCL is high. Address bits are sampled on SCL rising edges. Bytes clocked without a preceding START are never acknowledged.
- R3: On a match, `sda_pull` goes high after the SCL falling edge that ends the eighth bit and stays high until the SCL falling edge that ends the ninth bit. On a mismatch, `sda_pull` stays low.
- R4: For a full match, `match_stb` pulses for one cycle once the deciding byte is in. `irq_stb` pulses for one cycle only after the falling edge that ends the ninth clock, and never earlier. `addressed` is then set.
- R5: With `ten_bit_en` = 1, a first byte whose bits 7..1 equal 1,1,1,1,0,`own_addr[9]`,`own_addr[8]` and whose bit 0 is 0 is acknowledged. It clears `ten_match`, raises no interrupt, and makes the next byte the low address byte.
- R6: The low byte is acknowledged only if it equals `own_addr[7:0]`. That match sets `ten_match` and raises the interrupt. A mismatch clears `ten_match`, is not acknowledged, and returns the block to idle.
- R7: In 10-bit mode, a first byte whose bits 7..1 do not match the header is not acknowledged. The same holds for a matching header with bit 0 = 1 while `ten_match` is clear. In both cases `ten_match` is cleared and the block goes idle.
- R8: While `ten_match` is set, a repeated START followed by the header with bit 0 = 1 is acknowledged. It sets `dir_read` and `addressed` and raises the interrupt.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle. It releases `sda_pull` and clears `addressed`, `dir_read` and `ten_match`.
- R10: The all-zero first byte (general call) is acknowledged as a full write match in either mode only when `gcall_en` = 1.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| ten_bit_en | input | 1 | 1 = 10-bit own address, 0 = 7-bit |
| own_addr | input | 10 | Own slave address |
| gcall_en | input | 1 | Acknowledge the general call |
| sda_pull | output | 1 | Drive SDA low (acknowledge) |
| match_stb | output | 1 | One-cycle full-match strobe |
| irq_stb | output | 1 | One-cycle interrupt pulse after the ninth clock |
| dir_read | output | 1 | Direction of the matched transfer, 1 = read |
| ten_match | output | 1 | 10-bit status: 0 partial or none, 1 full |
| addressed | output | 1 | Slave selected until the next START or STOP |

## Verification
A wrong shift count or a bad comparison shows up on the bus in the same byte. The acknowledge appears or fails to appear during the ninth clock, so a single byte exposes it. A wrong 10-bit phase or status value shows up one byte later. That is when the low byte or a repeated-START read header is acknowledged or refused, and when `ten_match` and the interrupt count are checked against the expected values. The interrupt is counted at the middle of the ninth clock and again after it, which catches a pulse raised one bus phase early.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;
    localparam int SUB_W  = BYTE_W - 1;
    localparam int HDR_W  = 5;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [HDR_W-1:0] TEN_HDR = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_ADDRESSED
    } am_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef struct packed {
        logic ack;
        logic full;
        logic dir;
        logic ten_set;
        logic ten_clr;
    } verdict_t;

    function automatic logic [SUB_W-1:0] ten_header(input logic [ADDR_W-1:0] own);
        return {TEN_HDR, own[ADDR_W-1 -: HI_W]};
    endfunction

    function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
        return b == '0;
    endfunction

endpackage

// File: rtl/i2c_am_bus_events.sv
module i2c_am_bus_events
    import i2c_am_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.start = scl_i & scl_q & sda_q & ~sda_i;
        evt.stop  = scl_i & scl_q & ~sda_q & sda_i;
        evt.rise  = scl_i & ~scl_q;
        evt.fall  = ~scl_i & scl_q;
    end

endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              rise,
    input  logic              sda_i,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_vld
);

    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (start || stop) begin
                bit_cnt <= '0;
            end else if (rise) begin
                if (bit_cnt == ACK_SLOT) begin
                    bit_cnt <= '0;
                end else begin
                    shreg    <= {shreg[BYTE_W-2:0], sda_i};
                    bit_cnt  <= bit_cnt + 1'b1;
                    byte_vld <= (bit_cnt == LAST_DATA);
                end
            end
        end
    end

    assign rx_byte = shreg;

endmodule

// File: rtl/i2c_am_decoder.sv
module i2c_am_decoder
    import i2c_am_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit_en,
    input  logic              gcall_en,
    input  logic              second,
    input  logic              ten_full,
    output verdict_t          verdict
);

    logic [SUB_W-1:0] upper;

    assign upper = rx_byte[BYTE_W-1:1];

    always_comb begin
        verdict = '0;
        if (second) begin
            if (rx_byte == own_addr[BYTE_W-1:0]) begin
                verdict.ack     = 1'b1;
                verdict.full    = 1'b1;
                verdict.ten_set = 1'b1;
            end else begin
                verdict.ten_clr = 1'b1;
            end
        end else if (gcall_en && is_gcall(rx_byte)) begin
            verdict.ack  = 1'b1;
            verdict.full = 1'b1;
        end else if (!ten_bit_en) begin
            if (upper == own_addr[SUB_W-1:0]) begin
                verdict.ack  = 1'b1;
                verdict.full = 1'b1;
                verdict.dir  = rx_byte[0];
            end
        end else if (upper == ten_header(own_addr)) begin
            if (!rx_byte[0]) begin
                verdict.ack     = 1'b1;
                verdict.ten_clr = 1'b1;
            end else if (ten_full) begin
                verdict.ack  = 1'b1;
                verdict.full = 1'b1;
                verdict.dir  = 1'b1;
            end else begin
                verdict.ten_clr = 1'b1;
            end
        end else begin
            verdict.ten_clr = 1'b1;
        end
    end

endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
    import i2c_am_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     stop,
    input  logic     fall,
    input  logic     byte_vld,
    input  verdict_t verdict,
    output logic     second,
    output logic     sda_pull,
    output logic     match_stb,
    output logic     irq_stb,
    output logic     dir_read,
    output logic     ten_match,
    output logic     addressed
);

    am_state_e state;
    logic      full_pend;

    assign second = (state == ST_ADDR2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            full_pend <= 1'b0;
            sda_pull  <= 1'b0;
            match_stb <= 1'b0;
            irq_stb   <= 1'b0;
            dir_read  <= 1'b0;
            ten_match <= 1'b0;
            addressed <= 1'b0;
        end else begin
            match_stb <= 1'b0;
            irq_stb   <= 1'b0;
            if (stop) begin
                state     <= ST_IDLE;
                sda_pull  <= 1'b0;
                addressed <= 1'b0;
                dir_read  <= 1'b0;
                ten_match <= 1'b0;
            end else if (start) begin
                state     <= ST_ADDR1;
                sda_pull  <= 1'b0;
                addressed <= 1'b0;
                dir_read  <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR1, ST_ADDR2: begin
                        if (byte_vld) begin
                            if (verdict.ten_set) ten_match <= 1'b1;
                            if (verdict.ten_clr) ten_match <= 1'b0;
                            if (verdict.ack) begin
                                state     <= ST_ACK_WAIT;
                                full_pend <= verdict.full;
                                if (verdict.full) begin
                                    match_stb <= 1'b1;
                                    dir_read  <= verdict.dir;
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (fall) begin
                            sda_pull <= 1'b1;
                            state    <= ST_ACK_DRIVE;
                        end
                    end
                    ST_ACK_DRIVE: begin
                        if (fall) begin
                            sda_pull <= 1'b0;
                            if (full_pend) begin
                                irq_stb   <= 1'b1;
                                addressed <= 1'b1;
                                state     <= ST_ADDRESSED;
                            end else begin
                                state <= ST_ADDR2;
                            end
                        end
                    end
                    default: state <= state;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              ten_bit_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gcall_en,
    output logic              sda_pull,
    output logic              match_stb,
    output logic              irq_stb,
    output logic              dir_read,
    output logic              ten_match,
    output logic              addressed
);

    bus_evt_t          evt;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_vld;
    logic              second;
    verdict_t          verdict;

    i2c_am_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_am_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (evt.start),
        .stop     (evt.stop),
        .rise     (evt.rise),
        .sda_i    (sda_i),
        .rx_byte  (rx_byte),
        .byte_vld (byte_vld)
    );

    i2c_am_decoder u_dec (
        .rx_byte    (rx_byte),
        .own_addr   (own_addr),
        .ten_bit_en (ten_bit_en),
        .gcall_en   (gcall_en),
        .second     (second),
        .ten_full   (ten_match),
        .verdict    (verdict)
    );

    i2c_am_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (evt.start),
        .stop      (evt.stop),
        .fall      (evt.fall),
        .byte_vld  (byte_vld),
        .verdict   (verdict),
        .second    (second),
        .sda_pull  (sda_pull),
        .match_stb (match_stb),
        .irq_stb   (irq_stb),
        .dir_read  (dir_read),
        .ten_match (ten_match),
        .addressed (addressed)
    );

endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_i,
    input logic ten_bit_en,
    input logic sda_pull,
    input logic match_stb,
    input logic irq_stb,
    input logic ten_match,
    input logic addressed
);

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_stb |=> !irq_stb); // R4

    AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        match_stb |=> !match_stb); // R4

    AST_IRQ_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_stb) |-> (!$past(scl_i) && $past(scl_i, 2))); // R4

    AST_PULL_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_i); // R3

    AST_RELEASE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull) |-> !scl_i); // R3

    AST_TEN_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(ten_match) |-> ten_bit_en); // R6

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> (!addressed && !sda_pull && !ten_match)); // R9

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (.*);

// File: tb/test_i2c_addr_match.sv
module test_i2c_addr_match;

    localparam int H = 4;
    localparam int NVEC = 8;

    // {ten, gcall, own[9:0], byte[7:0], exp_ack, exp_irq, exp_dir}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 10'h02A, 8'h54, 1'b1, 1'b1, 1'b0},   // R1 write match
        {1'b0, 1'b0, 10'h02A, 8'h55, 1'b1, 1'b1, 1'b1},   // R1 read match
        {1'b0, 1'b0, 10'h02A, 8'h56, 1'b0, 1'b0, 1'b0},   // R1 mismatch
        {1'b0, 1'b0, 10'h3AA, 8'h54, 1'b1, 1'b1, 1'b0},   // R1 upper bits ignored
        {1'b0, 1'b0, 10'h02A, 8'h00, 1'b0, 1'b0, 1'b0},   // R10 gcall off
        {1'b0, 1'b1, 10'h02A, 8'h00, 1'b1, 1'b1, 1'b0},   // R10 gcall on
        {1'b1, 1'b0, 10'h02A, 8'h54, 1'b0, 1'b0, 1'b0},   // R7 header mismatch
        {1'b1, 1'b1, 10'h02A, 8'h00, 1'b1, 1'b1, 1'b0}    // R10 gcall 10-bit
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       ten_bit_en = 1'b0;
    logic [9:0] own_addr = '0;
    logic       gcall_en = 1'b0;
    logic       sda_pull, match_stb, irq_stb, dir_read, ten_match, addressed;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    int mt_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    i2c_addr_match i_i2c_addr_match (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .ten_bit_en (ten_bit_en),
        .own_addr   (own_addr),
        .gcall_en   (gcall_en),
        .sda_pull   (sda_pull),
        .match_stb  (match_stb),
        .irq_stb    (irq_stb),
        .dir_read   (dir_read),
        .ten_match  (ten_match),
        .addressed  (addressed)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (irq_stb) irq_cnt++;
            if (match_stb) mt_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; hold();
        scl = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic bus_byte(input logic [7:0] b, output bit acked, output int irq_mid);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold();
            scl = 1'b1; hold();
            scl = 1'b0;
        end
        sda_m = 1'b1; hold();
        scl = 1'b1;
        repeat (H / 2) @(negedge clk);
        acked = !sda_bus;
        irq_mid = irq_cnt;
        repeat (H / 2) @(negedge clk);
        scl = 1'b0; hold();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit ack;
        int imid;
        int i0;
        int m0;
        repeat (5) @(negedge clk);
        chk("R11 sda_pull", sda_pull, 0);
        chk("R11 irq_stb", irq_stb, 0);
        chk("R11 addressed", addressed, 0);
        rst = 1'b0;
        hold();
        chk("R11 ten_match", ten_match, 0);
        chk("R11 dir_read", dir_read, 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            ten_bit_en = VEC[v][22];
            gcall_en   = VEC[v][21];
            own_addr   = VEC[v][20:11];
            i0 = irq_cnt;
            bus_start();
            bus_byte(VEC[v][10:3], ack, imid);
            chk($sformatf("R3 vec%0d ack", v), ack, VEC[v][2]);
            chk($sformatf("R4 vec%0d irq not early", v), imid - i0, 0);
            chk($sformatf("R4 vec%0d irq count", v), irq_cnt - i0, VEC[v][1]);
            if (VEC[v][2]) chk($sformatf("R1 vec%0d dir", v), dir_read, VEC[v][0]);
            bus_stop();
        end

        // 10-bit full match, own = 0x2A5 -> header 0xF4/0xF5, low byte 0xA5
        ten_bit_en = 1'b1; gcall_en = 1'b0; own_addr = 10'h2A5;
        i0 = irq_cnt; m0 = mt_cnt;
        bus_start();
        bus_byte(8'hF4, ack, imid);
        chk("R5 header ack", ack, 1);
        chk("R5 header ten_match", ten_match, 0);
        chk("R5 header no irq", irq_cnt - i0, 0);
        bus_byte(8'hA5, ack, imid);
        chk("R6 low byte ack", ack, 1);
        chk("R6 ten_match set", ten_match, 1);
        chk("R6 irq raised", irq_cnt - i0, 1);
        chk("R4 match strobe once", mt_cnt - m0, 1);
        chk("R4 addressed", addressed, 1);

        // repeated start read header
        bus_rstart();
        bus_byte(8'hF5, ack, imid);
        chk("R8 read header ack", ack, 1);
        chk("R8 dir_read", dir_read, 1);
        chk("R8 addressed", addressed, 1);
        chk("R8 irq", irq_cnt - i0, 2);
        bus_stop();
        chk("R9 ten_match cleared", ten_match, 0);
        chk("R9 addressed cleared", addressed, 0);
        chk("R9 sda released", sda_pull, 0);

        // low byte mismatch
        i0 = irq_cnt;
        bus_start();
        bus_byte(8'hF4, ack, imid);
        bus_byte(8'hA6, ack, imid);
        chk("R6 low mismatch nack", ack, 0);
        chk("R6 low mismatch ten_match", ten_match, 0);
        chk("R6 low mismatch no irq", irq_cnt - i0, 0);
        bus_stop();

        // read header without prior full match
        bus_start();
        bus_byte(8'hF5, ack, imid);
        chk("R7 read header refused", ack, 0);
        bus_stop();

        // wrong A9/A8
        bus_start();
        bus_byte(8'hF6, ack, imid);
        chk("R7 wrong top bits", ack, 0);
        bus_stop();

        // after full match, write header again clears status
        bus_start();
        bus_byte(8'hF4, ack, imid);
        bus_byte(8'hA5, ack, imid);
        chk("R6 full again", ten_match, 1);
        bus_rstart();
        bus_byte(8'hF4, ack, imid);
        chk("R5 rewrite header ack", ack, 1);
        chk("R5 rewrite clears status", ten_match, 0);
        bus_stop();

        // bytes without START are ignored
        ten_bit_en = 1'b0; own_addr = 10'h02A;
        i0 = irq_cnt;
        bus_byte(8'h54, ack, imid);
        chk("R2 no start no ack", ack, 0);
        chk("R2 no start no irq", irq_cnt - i0, 0);
        bus_stop();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule